// File: doc/BRIEF.md
# Analog column clock selector

This block produces the clocks for four analog columns. Two shared intermediate clocks each pick one of eight digital-block clock outputs. Each column then picks one of four sources: one of two base system clocks, or one of the two intermediate clocks. The chosen source is divided by four and becomes that column's clock. One column clock drives every analog block in its column.

Everything runs in one fast reference-clock domain. All source clocks are sampled there as plain levels. Each divider is a 2-bit counter that steps on sampled rising edges of its source. The divider's top bit is the column output, so the output is high for two source periods and low for two. A change to a column's select field waits for a period boundary before it is adopted, so no short pulse reaches the column.

Two configuration registers sit behind a small write/read port. The intermediate-select register is at address 0. The column-select register is at address 1.

Top module: `col_clk_router`

## Requirements
- R1: Intermediate clock A is `dig_clk[n]`, where n is bits [2:0] of the intermediate-select register (address 0).
- R2: Intermediate clock B is `dig_clk[m]`, where m is bits [5:3] of the same register, chosen independently of A.
- R3: Column k takes its source from bits [2k+1:2k] of the column-select register (address 1). The codes are 00 for `base_clk1`, 01 for `base_clk2`, 10 for intermediate A and 11 for intermediate B.
- R4: Each column output divides its source by four. It is low after reset, goes high after the second sampled rising edge of its source and low again after the fourth. It changes two reference cycles after the input edge it counts. It holds its value when the source shows no rising edge.
- R5: A changed column select field is adopted only when that column's divider count is zero, which is the start of a period with the output low. The switch cycle counts no edge, and an edge is counted only if it belongs to the new source.
- R6: After reset both registers read zero, every column selects `base_clk1`, and every column output is low.
- R7: A write with `cfg_we` high updates the register at `cfg_addr` on the next reference edge. `cfg_rdata` shows the register at `cfg_raddr` without delay. Bits [7:6] of address 0 always read zero.
- R8: A change to an intermediate select takes effect on the next cycle, with no wait for a period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| base_clk1 | input | 1 | Base system clock 1, sampled as a level |
| base_clk2 | input | 1 | Base system clock 2, sampled as a level |
| dig_clk | input | 8 | Clock outputs of the eight digital blocks |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Write address: 0 intermediate select, 1 column select |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 1 | Read address |
| cfg_rdata | output | 8 | Read data of the addressed register |
| col_clk | output | 4 | Column clocks, bit k for column k |

## Verification
The assertions check four things on every cycle:
- a column's active source changes only when its count was zero;
- the count advances by one exactly on a counted edge and otherwise stays still;
- a column output changes only after a counted edge;
- written data lands in the addressed register.

Only the bench's scenarios can show the rest: that the routing through both select stages picks the intended digital block or base clock, that the column waveform has the right period and phase, and that selection changes made mid-period are adopted at the expected boundary. Frozen sources show that the outputs hold.

// File: rtl/col_clk_pkg.sv
package col_clk_pkg;
  localparam int unsigned NUM_DIG   = 8;
  localparam int unsigned NUM_COL   = 4;
  localparam int unsigned DSEL_W    = $clog2(NUM_DIG);
  localparam int unsigned CSEL_W    = 2;
  localparam int unsigned NUM_CAND  = 1 << CSEL_W;
  localparam int unsigned DIV_W     = 2;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ISEL_USED = 2 * DSEL_W;

  typedef enum logic [CSEL_W-1:0] {
    SRC_BASE1 = 2'b00,
    SRC_BASE2 = 2'b01,
    SRC_MIDA  = 2'b10,
    SRC_MIDB  = 2'b11
  } col_src_e;

  function automatic logic [CSEL_W-1:0] col_field(input logic [REG_W-1:0] r, input int unsigned k);
    return r[k*CSEL_W +: CSEL_W];
  endfunction

  function automatic logic [DIV_W-1:0] div_next(input logic [DIV_W-1:0] c, input logic step);
    return step ? c + 1'b1 : c;
  endfunction
endpackage

// File: rtl/ccr_cfg_regs.sv
module ccr_cfg_regs
  import col_clk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 waddr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 raddr,
  output logic [REG_W-1:0]     rdata,
  output logic [ISEL_USED-1:0] isel_reg,
  output logic [REG_W-1:0]     csel_reg
);
  localparam int unsigned PAD_W = REG_W - ISEL_USED;

  wire wr_isel = we && !waddr;
  wire wr_csel = we && waddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      isel_reg <= '0;
      csel_reg <= '0;
    end else begin
      if (wr_isel) isel_reg <= wdata[ISEL_USED-1:0];
      if (wr_csel) csel_reg <= wdata;
    end
  end

  always_comb rdata = raddr ? csel_reg : {{PAD_W{1'b0}}, isel_reg};

  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    wr_csel |=> (csel_reg == $past(wdata)));
endmodule

// File: rtl/ccr_src_mux.sv
module ccr_src_mux
  import col_clk_pkg::*;
(
  input  logic [NUM_DIG-1:0]   dig_q,
  input  logic [ISEL_USED-1:0] isel,
  output logic                 mid_a,
  output logic                 mid_b
);
  wire [DSEL_W-1:0] sel_a = isel[DSEL_W-1:0];
  wire [DSEL_W-1:0] sel_b = isel[ISEL_USED-1:DSEL_W];

  always_comb begin
    mid_a = dig_q[sel_a];
    mid_b = dig_q[sel_b];
  end
endmodule

// File: rtl/ccr_col_div.sv
module ccr_col_div
  import col_clk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CAND-1:0] cand,
  input  logic [CSEL_W-1:0]   cfg_sel,
  output logic                col_out
);
  logic [CSEL_W-1:0] act_sel;
  logic              prev_lvl;
  logic [DIV_W-1:0]  cnt;

  wire lvl_act   = cand[act_sel];
  wire lvl_new   = cand[cfg_sel];
  wire at_bound  = (cnt == '0);
  wire do_switch = at_bound && (cfg_sel != act_sel);
  wire rise      = !do_switch && lvl_act && !prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel  <= SRC_BASE1;
      prev_lvl <= 1'b0;
      cnt      <= '0;
    end else if (do_switch) begin
      act_sel  <= cfg_sel;
      prev_lvl <= lvl_new;
    end else begin
      prev_lvl <= lvl_act;
      cnt      <= div_next(cnt, rise);
    end
  end

  assign col_out = cnt[DIV_W-1];

  p_switch_at_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (act_sel != $past(act_sel)) |-> ($past(cnt) == '0));
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt == $past(cnt) + 1'b1));
  p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(cnt));
  p_out_after_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(col_out) |-> $past(rise));
endmodule

// File: rtl/col_clk_router.sv
module col_clk_router
  import col_clk_pkg::*;
(
  input  logic               ref_clk,
  input  logic               rst,
  input  logic               base_clk1,
  input  logic               base_clk2,
  input  logic [NUM_DIG-1:0] dig_clk,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               cfg_raddr,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic [NUM_COL-1:0] col_clk
);
  logic [ISEL_USED-1:0] isel_reg;
  logic [REG_W-1:0]     csel_reg;
  logic [NUM_DIG-1:0]   dig_q;
  logic                 base1_q, base2_q;
  logic                 mid_a, mid_b;
  logic [NUM_CAND-1:0]  cand;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      dig_q   <= '0;
      base1_q <= 1'b0;
      base2_q <= 1'b0;
    end else begin
      dig_q   <= dig_clk;
      base1_q <= base_clk1;
      base2_q <= base_clk2;
    end
  end

  ccr_cfg_regs u_regs (
    .clk(ref_clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .isel_reg(isel_reg), .csel_reg(csel_reg)
  );

  ccr_src_mux u_mux (.dig_q(dig_q), .isel(isel_reg), .mid_a(mid_a), .mid_b(mid_b));

  always_comb begin
    cand            = '0;
    cand[SRC_BASE1] = base1_q;
    cand[SRC_BASE2] = base2_q;
    cand[SRC_MIDA]  = mid_a;
    cand[SRC_MIDB]  = mid_b;
  end

  for (genvar k = 0; k < NUM_COL; k++) begin : g_col
    ccr_col_div u_div (
      .clk(ref_clk), .rst(rst), .cand(cand),
      .cfg_sel(col_field(csel_reg, k)), .col_out(col_clk[k])
    );
  end
endmodule

// File: tb/col_clk_router_tb.sv
module col_clk_router_tb_top;
  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_clk1 = 1'b0, base_clk2 = 1'b0;
  logic [7:0] dig_clk = '0;
  logic       cfg_we = 1'b0, cfg_addr = 1'b0, cfg_raddr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] col_clk;

  int n_vec = 0, n_bad = 0;
  int tick = 0;
  bit freeze = 0;
  logic [3:0] exp_q[$];

  // reference model state
  logic [5:0] m_isel;
  logic [7:0] m_csel;
  logic [7:0] m_dig;
  logic       m_b1, m_b2;
  int         m_cnt[4];
  logic [1:0] m_act[4];
  logic       m_prev[4];

  col_clk_router dut_i (.*);

  always #10 ref_clk = ~ref_clk;

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic logic pick_src(input logic [1:0] s);
    case (s)
      2'd0: return m_b1;
      2'd1: return m_b2;
      2'd2: return m_dig[m_isel[2:0]];
      default: return m_dig[m_isel[5:3]];
    endcase
  endfunction

  // model: steps on every reference edge, pushes expected column outputs
  always @(posedge ref_clk) begin
    if (rst) begin
      m_isel = '0; m_csel = '0; m_dig = '0; m_b1 = 0; m_b2 = 0;
      for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_act[k] = 0; m_prev[k] = 0; end
      exp_q.delete();
    end else begin
      logic [3:0] e;
      for (int k = 0; k < 4; k++) begin
        logic [1:0] want;
        logic lv;
        want = m_csel[2*k +: 2];
        if (m_cnt[k] == 0 && want != m_act[k]) begin
          m_act[k] = want;
          m_prev[k] = pick_src(want);
        end else begin
          lv = pick_src(m_act[k]);
          if (lv && !m_prev[k]) m_cnt[k] = (m_cnt[k] + 1) % 4;
          m_prev[k] = lv;
        end
        e[k] = (m_cnt[k] >= 2);
      end
      m_dig = dig_clk; m_b1 = base_clk1; m_b2 = base_clk2;
      if (cfg_we && !cfg_addr) m_isel = cfg_wdata[5:0];
      if (cfg_we && cfg_addr)  m_csel = cfg_wdata;
      exp_q.push_back(e);
    end
  end

  // monitor: compares the design's outputs against the scoreboard
  always @(negedge ref_clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      n_vec++;
      if (col_clk !== e) begin
        n_bad++;
        $display("FAIL R4 column divide (routing R1 R2 R3 R5 R8) t=%0t: actual=%b expected=%b",
                 $time, col_clk, e);
      end
    end
  end

  // source waveforms, driven away from the active edge
  always @(negedge ref_clk) begin
    if (!freeze) begin
      tick++;
      base_clk1 <= tick[0];
      base_clk2 <= tick[1];
      for (int n = 0; n < 8; n++) dig_clk[n] <= ((tick / (n + 2)) % 2) != 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge ref_clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge ref_clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    cfg_raddr = a;
    #1;
    chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    rst = 0;
    // R6 reset state
    rd_chk(0, 8'h00, "R6 isel after reset");
    rd_chk(1, 8'h00, "R6 csel after reset");
    chk(col_clk === 4'h0, "R6 columns low after reset", col_clk, 0);
    run(30);
    // R7 write and readback, R3 routing of every code
    wr(1, 8'b11_10_01_00);
    rd_chk(1, 8'hE4, "R7 csel readback");
    // R1 R2 select A=3, B=6; R7 bits 7:6 read zero
    wr(0, 8'b11_110_011);
    rd_chk(0, 8'h33, "R7 isel readback upper bits zero");
    run(150);
    // R5 column changes mid-period
    wr(1, 8'b00_11_10_01);
    run(7);
    wr(1, 8'b01_00_11_10);
    run(150);
    // R8 intermediate changes under running columns
    wr(0, 8'b00_111_000);
    rd_chk(0, 8'h38, "R8 isel readback");
    run(120);
    wr(0, 8'b00_001_101);
    run(60);
    // R4 frozen sources: outputs must hold
    freeze = 1;
    run(40);
    freeze = 0;
    run(80);
    // R7 write latency: not visible before the edge
    cfg_raddr = 1;
    @(negedge ref_clk);
    cfg_we = 1; cfg_addr = 1; cfg_wdata = 8'h5A;
    #1;
    chk(cfg_rdata === 8'h4E, "R7 old value before edge", cfg_rdata, 8'h4E);
    @(negedge ref_clk);
    cfg_we = 0;
    #1;
    chk(cfg_rdata === 8'h5A, "R7 new value after edge", cfg_rdata, 8'h5A);
    run(100);
    // R6 reset again mid-run
    @(negedge ref_clk);
    rst = 1;
    run(2);
    rst = 0;
    #1;
    chk(col_clk === 4'h0, "R6 columns low after second reset", col_clk, 0);
    rd_chk(1, 8'h00, "R6 csel cleared");
    run(40);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule